// File: doc/BRIEF.md
# Windowed Display RAM Address Generator

This block produces the display-RAM address for host data accesses that fall inside a rectangular window. The host sets a row (page) range and a column range. It also picks which axis moves on every access and whether each axis is mirrored. Each access strobe moves the address one step through the window. When the fast axis passes its last line, it returns to its first line and the slow axis moves by one. The address leaves the block as a physical page and column, with mirroring already applied. A one-cycle flag marks the access that closes the whole window.

Loading a window range or a mode returns the address to the window origin. Ranges are clamped, so the window is always legal: a value beyond the last line becomes the last line, and an end below its start collapses that axis to a single line. Read and write accesses move the address in the same way.

Top module: `win_addr_gen`

## Requirements
- R1: After a synchronous reset, both windows cover lines 0 to 131, both axes are unmirrored, the scan is page-major, the outputs read page 0 and column 0, and `win_done` is 0.
- R2: With `scan_col`=0 (page-major), each access adds one to the page. An access made at the end page sets the page to the start page and adds one to the column.
- R3: With `scan_col`=1 (column-major), each access adds one to the column. An access made at the end column sets the column to the start column and adds one to the page.
- R4: An access made while both axes sit at their end values returns the address to the window origin (start page, start column). `win_done` is 1 in the following cycle only. It is 0 after every other access or idle cycle.
- R5: With `page_mirror`=1, `phys_page` equals 131 minus the logical page.
- R6: With `col_mirror`=1, `phys_col` equals 131 minus the logical column.
- R7: A pulse on `page_load`, `col_load` or `mode_load` sets the address to the start page and start column of the resulting window and clears `win_done`. If an access strobe arrives in the same cycle as a load, the strobe is ignored.
- R8: A loaded start or end value above 131 is taken as 131. If the loaded end is below the loaded start, the end is set to the start.
- R9: `acc_write` has no effect: read accesses (0) and write accesses (1) move the address identically.
- R10: With no strobe and no load, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| page_load | input | 1 | Load the page range |
| page_start | input | 8 | Requested start page |
| page_end | input | 8 | Requested end page |
| col_load | input | 1 | Load the column range |
| col_start | input | 8 | Requested start column |
| col_end | input | 8 | Requested end column |
| mode_load | input | 1 | Load the scan and mirror controls |
| scan_col | input | 1 | 0: page-major scan, 1: column-major scan |
| page_mirror | input | 1 | Mirror the page axis |
| col_mirror | input | 1 | Mirror the column axis |
| acc_strobe | input | 1 | One host data access (read or write) |
| acc_write | input | 1 | Access type, 1 for write (no effect on addressing) |
| phys_page | output | 8 | Physical page address |
| phys_col | output | 8 | Physical column address |
| win_done | output | 1 | Pulse: the last access closed the window |

## Verification
Every result of this block is due one clock edge after its cause. The clock edge that samples a strobe or a load also updates `phys_page`, `phys_col` and `win_done`. The bench drives each stimulus at a falling edge and checks the outputs at the next falling edge, after exactly one rising edge. A reference model in the bench advances the window arithmetically on the same step. The idle checks wait further falling edges, to show that the address holds and that `win_done` falls after one cycle.

// File: rtl/win_addr_pkg.sv
package win_addr_pkg;
  typedef enum logic {
    SCAN_PAGE = 1'b0,
    SCAN_COL  = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/win_axis_bounds.sv
// Holds one axis range. Clamps values on load so that start <= end <= N-1.
module win_axis_bounds #(
  parameter int N  = 132,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_in,
  input  logic [AW-1:0] end_in,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] end_q,
  output logic [AW-1:0] start_d
);
  localparam logic [AW-1:0] MAXV = AW'(N - 1);

  logic [AW-1:0] s_clamp, e_lim, e_clamp;

  always_comb begin
    s_clamp = (start_in > MAXV) ? MAXV : start_in;
    e_lim   = (end_in   > MAXV) ? MAXV : end_in;
    e_clamp = (e_lim < s_clamp) ? s_clamp : e_lim;
    start_d = load ? s_clamp : start_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= MAXV;
    end else if (load) begin
      start_q <= s_clamp;
      end_q   <= e_clamp;
    end
  end
endmodule

// File: rtl/win_axis_step.sv
// Next-value logic for one axis of the window counter.
module win_axis_step #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] start_v,
  input  logic [AW-1:0] end_v,
  input  logic          en,
  output logic          at_end,
  output logic [AW-1:0] nxt
);
  always_comb begin
    at_end = (cur == end_v);
    if (!en)        nxt = cur;
    else if (at_end) nxt = start_v;
    else            nxt = cur + 1'b1;
  end
endmodule

// File: rtl/win_axis_mirror.sv
// Maps a logical line number to a physical one, reversed when inv is set.
module win_axis_mirror #(
  parameter int N  = 132,
  parameter int AW = $clog2(N)
) (
  input  logic [AW-1:0] logical,
  input  logic          inv,
  output logic [AW-1:0] physical
);
  localparam logic [AW-1:0] MAXV = AW'(N - 1);

  assign physical = inv ? (MAXV - logical) : logical;
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import win_addr_pkg::*;
#(
  parameter int N_PAGES = 132,
  parameter int N_COLS  = 132,
  parameter int PAW     = 8,
  parameter int CAW     = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           page_load,
  input  logic [PAW-1:0] page_start,
  input  logic [PAW-1:0] page_end,
  input  logic           col_load,
  input  logic [CAW-1:0] col_start,
  input  logic [CAW-1:0] col_end,
  input  logic           mode_load,
  input  logic           scan_col,
  input  logic           page_mirror,
  input  logic           col_mirror,
  input  logic           acc_strobe,
  input  logic           acc_write,
  output logic [PAW-1:0] phys_page,
  output logic [CAW-1:0] phys_col,
  output logic           win_done
);
  // acc_write has no effect on addressing; reads and writes step the same way.
  logic unused_write;
  assign unused_write = acc_write;

  scan_dir_e scan_q, scan_d;
  logic      pinv_q, pinv_d, cinv_q, cinv_d;
  logic      any_load;

  logic [PAW-1:0] ps_q, pe_q, ps_d, pg_q, pg_nxt, pg_d, pg_phys_d;
  logic [CAW-1:0] cs_q, ce_q, cs_d, cl_q, cl_nxt, cl_d, cl_phys_d;
  logic           pg_at_end, cl_at_end, pg_en, cl_en, done_d;

  assign any_load = page_load | col_load | mode_load;

  win_axis_bounds #(.N(N_PAGES), .AW(PAW)) u_page_bounds (
    .clk(clk), .rst(rst), .load(page_load),
    .start_in(page_start), .end_in(page_end),
    .start_q(ps_q), .end_q(pe_q), .start_d(ps_d)
  );

  win_axis_bounds #(.N(N_COLS), .AW(CAW)) u_col_bounds (
    .clk(clk), .rst(rst), .load(col_load),
    .start_in(col_start), .end_in(col_end),
    .start_q(cs_q), .end_q(ce_q), .start_d(cs_d)
  );

  // The major axis steps on every access. The minor axis steps when the major axis wraps.
  always_comb begin
    pg_en = acc_strobe & ((scan_q == SCAN_COL) ? cl_at_end : 1'b1);
    cl_en = acc_strobe & ((scan_q == SCAN_PAGE) ? pg_at_end : 1'b1);
  end

  win_axis_step #(.AW(PAW)) u_page_step (
    .cur(pg_q), .start_v(ps_q), .end_v(pe_q), .en(pg_en),
    .at_end(pg_at_end), .nxt(pg_nxt)
  );

  win_axis_step #(.AW(CAW)) u_col_step (
    .cur(cl_q), .start_v(cs_q), .end_v(ce_q), .en(cl_en),
    .at_end(cl_at_end), .nxt(cl_nxt)
  );

  always_comb begin
    scan_d = mode_load ? scan_dir_e'(scan_col) : scan_q;
    pinv_d = mode_load ? page_mirror : pinv_q;
    cinv_d = mode_load ? col_mirror  : cinv_q;
    if (any_load) begin
      pg_d   = ps_d;
      cl_d   = cs_d;
      done_d = 1'b0;
    end else begin
      pg_d   = pg_nxt;
      cl_d   = cl_nxt;
      done_d = acc_strobe & pg_at_end & cl_at_end;
    end
  end

  win_axis_mirror #(.N(N_PAGES), .AW(PAW)) u_page_mirror (
    .logical(pg_d), .inv(pinv_d), .physical(pg_phys_d)
  );

  win_axis_mirror #(.N(N_COLS), .AW(CAW)) u_col_mirror (
    .logical(cl_d), .inv(cinv_d), .physical(cl_phys_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q    <= SCAN_PAGE;
      pinv_q    <= 1'b0;
      cinv_q    <= 1'b0;
      pg_q      <= '0;
      cl_q      <= '0;
      phys_page <= '0;
      phys_col  <= '0;
      win_done  <= 1'b0;
    end else begin
      scan_q    <= scan_d;
      pinv_q    <= pinv_d;
      cinv_q    <= cinv_d;
      pg_q      <= pg_d;
      cl_q      <= cl_d;
      phys_page <= pg_phys_d;
      phys_col  <= cl_phys_d;
      win_done  <= done_d;
    end
  end
endmodule

// File: rtl/win_addr_gen_chk.sv
module win_addr_gen_chk #(
  parameter int N_PAGES = 132,
  parameter int N_COLS  = 132,
  parameter int PAW     = 8,
  parameter int CAW     = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           page_load,
  input logic           col_load,
  input logic           mode_load,
  input logic           acc_strobe,
  input logic [PAW-1:0] phys_page,
  input logic [CAW-1:0] phys_col,
  input logic           win_done
);
  assert_done_after_access_R4: assert property (@(posedge clk) disable iff (rst)
    win_done |-> $past(acc_strobe));

  assert_load_clears_done_R7: assert property (@(posedge clk) disable iff (rst)
    (page_load || col_load || mode_load) |=> !win_done);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!acc_strobe && !page_load && !col_load && !mode_load)
      |=> ($stable(phys_page) && $stable(phys_col)));

  assert_page_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    phys_page < PAW'(N_PAGES));

  assert_col_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    phys_col < CAW'(N_COLS));
endmodule

bind win_addr_gen win_addr_gen_chk #(
  .N_PAGES(N_PAGES), .N_COLS(N_COLS), .PAW(PAW), .CAW(CAW)
) u_chk (
  .clk(clk), .rst(rst), .page_load(page_load), .col_load(col_load),
  .mode_load(mode_load), .acc_strobe(acc_strobe), .phys_page(phys_page),
  .phys_col(phys_col), .win_done(win_done)
);

// File: tb/win_addr_gen_tb.sv
`timescale 1ns/1ps
module win_addr_gen_tb;
  localparam int NL = 132;

  logic       clk = 1'b0;
  logic       rst;
  logic       page_load, col_load, mode_load, scan_col, page_mirror, col_mirror;
  logic [7:0] page_start, page_end, col_start, col_end;
  logic       acc_strobe, acc_write;
  logic [7:0] phys_page, phys_col;
  logic       win_done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference model state
  int  m_ps, m_pe, m_cs, m_ce, m_pg, m_cl;
  bit  m_scol, m_pinv, m_cinv, m_done;

  always #2.5 clk = ~clk;

  win_addr_gen u_dut (
    .clk(clk), .rst(rst),
    .page_load(page_load), .page_start(page_start), .page_end(page_end),
    .col_load(col_load), .col_start(col_start), .col_end(col_end),
    .mode_load(mode_load), .scan_col(scan_col), .page_mirror(page_mirror),
    .col_mirror(col_mirror), .acc_strobe(acc_strobe), .acc_write(acc_write),
    .phys_page(phys_page), .phys_col(phys_col), .win_done(win_done)
  );

  function automatic int clampv(int v);
    return (v > NL - 1) ? NL - 1 : v;
  endfunction

  task automatic check(string tag);
    int ep, ec;
    ep = m_pinv ? (NL - 1 - m_pg) : m_pg;
    ec = m_cinv ? (NL - 1 - m_cl) : m_cl;
    n_checks++;
    if (phys_page !== 8'(ep) || phys_col !== 8'(ec) || win_done !== m_done) begin
      n_fail++;
      $display("FAIL %s: page=%0d col=%0d done=%0b expected page=%0d col=%0d done=%0b",
               tag, phys_page, phys_col, win_done, ep, ec, m_done);
    end
  endtask

  task automatic model_step();
    bit pe_end, ce_end;
    pe_end = (m_pg == m_pe);
    ce_end = (m_cl == m_ce);
    m_done = pe_end && ce_end;
    if (!m_scol) begin
      m_pg = pe_end ? m_ps : m_pg + 1;
      if (pe_end) m_cl = ce_end ? m_cs : m_cl + 1;
    end else begin
      m_cl = ce_end ? m_cs : m_cl + 1;
      if (ce_end) m_pg = pe_end ? m_ps : m_pg + 1;
    end
  endtask

  task automatic model_origin();
    m_pg = m_ps; m_cl = m_cs; m_done = 0;
  endtask

  task automatic access(bit we, string tag);
    @(negedge clk);
    acc_strobe = 1; acc_write = we;
    model_step();
    @(negedge clk);
    acc_strobe = 0;
    check(tag);
  endtask

  task automatic load_pages(int s, int e, string tag);
    @(negedge clk);
    page_load = 1; page_start = 8'(s); page_end = 8'(e);
    m_ps = clampv(s); m_pe = clampv(e);
    if (m_pe < m_ps) m_pe = m_ps;
    model_origin();
    @(negedge clk);
    page_load = 0;
    check(tag);
  endtask

  task automatic load_cols(int s, int e, string tag);
    @(negedge clk);
    col_load = 1; col_start = 8'(s); col_end = 8'(e);
    m_cs = clampv(s); m_ce = clampv(e);
    if (m_ce < m_cs) m_ce = m_cs;
    model_origin();
    @(negedge clk);
    col_load = 0;
    check(tag);
  endtask

  task automatic load_mode(bit sc, bit pi, bit ci, string tag);
    @(negedge clk);
    mode_load = 1; scan_col = sc; page_mirror = pi; col_mirror = ci;
    m_scol = sc; m_pinv = pi; m_cinv = ci;
    model_origin();
    @(negedge clk);
    mode_load = 0;
    check(tag);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1; page_load = 0; col_load = 0; mode_load = 0;
    scan_col = 0; page_mirror = 0; col_mirror = 0;
    page_start = 0; page_end = 0; col_start = 0; col_end = 0;
    acc_strobe = 0; acc_write = 0;
    m_ps = 0; m_pe = NL - 1; m_cs = 0; m_ce = NL - 1;
    m_scol = 0; m_pinv = 0; m_cinv = 0;
    model_origin();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset state");

    // R2, R4, R9: full window page-major sweep, alternating reads and writes
    for (int i = 0; i < NL * NL; i++) access(i[0], "R2 R9 page-major full sweep");
    access(1, "R4 after full-window wrap");

    // R3, R4: full window column-major sweep
    load_mode(1, 0, 0, "R7 mode load origin");
    for (int i = 0; i < NL * NL; i++) access(i[1], "R3 column-major full sweep");

    // R5, R6: small mirrored window, both scan orders
    load_pages(5, 8, "R7 page load origin");
    load_cols(120, 123, "R7 col load origin");
    load_mode(0, 1, 1, "R5 R6 mirror mode load");
    for (int i = 0; i < 40; i++) access(i[0], "R5 R6 mirrored page-major");
    load_mode(1, 1, 0, "R5 mirror column-major load");
    for (int i = 0; i < 40; i++) access(0, "R5 R3 mirrored column-major");
    load_mode(0, 0, 1, "R6 col mirror load");
    for (int i = 0; i < 20; i++) access(1, "R6 col mirrored");

    // R8: clamping of out-of-range and inverted ranges
    load_pages(200, 250, "R8 page clamp above 131");
    load_cols(10, 3, "R8 col end below start");
    for (int i = 0; i < 4; i++) access(0, "R8 R4 single-cell window");
    load_cols(129, 255, "R8 col end clamp");
    load_pages(60, 2, "R8 page end below start");
    for (int i = 0; i < 8; i++) access(1, "R8 clamped col window");

    // R10: idle hold, and done falls after one cycle
    load_pages(0, 1, "R7 page load");
    load_cols(0, 0, "R7 col load");
    access(0, "R2 small");
    access(0, "R4 done on last cell");
    @(negedge clk); m_done = 0;
    check("R4 done low after one cycle");
    repeat (5) @(negedge clk);
    check("R10 idle hold");

    // R7: load and strobe in the same cycle, strobe ignored
    access(1, "R2 step before priority test");
    @(negedge clk);
    acc_strobe = 1; col_load = 1; col_start = 8'd7; col_end = 8'd9;
    m_cs = 7; m_ce = 9; model_origin();
    @(negedge clk);
    acc_strobe = 0; col_load = 0;
    check("R7 load beats strobe");
    access(0, "R7 R2 step after load");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule